// File: doc/BRIEF.md
# Serial Identity-Code CRC-8 Unit

This block computes an 8-bit cyclic redundancy check one bit at a time over the identity code of a single-wire device. The polynomial is x^8 + x^5 + x^4 + 1. The register starts from zero. Bits arrive least significant bit first. The 8-bit family field goes in first, followed by the 48 serial bits. After those 56 data bits, the register holds the check byte a sender appends.

A receiver shifts in all 64 bits of a code, including the received check byte. If the code is intact, the register returns to all zeros. A bit counter runs alongside the register so that the block can flag a code as good when exactly 64 bits have gone in and the residue is zero. A synchronous clear starts a new code. The clear takes priority over a bit offered in the same cycle.

Top module: `idcode_crc8`

## Requirements
- R1: After the active-low asynchronous reset, `crc_o` is 8'h00, `zero_o` is 1 and `code_ok_o` is 0.
- R2: On a clock edge where `bit_en_i` is 1 and `clr_i` is 0, the feedback bit is `bit_i` XOR `crc_o[0]`. The register shifts right by one, and when the feedback is 1 it is XORed with 8'h8C. The feedback bit lands in bit 7, and the taps sit at bits 3 and 2. The new value shows on `crc_o` after that edge.
- R3: On a clock edge where both `bit_en_i` and `clr_i` are 0, `crc_o` and the bit count keep their values, whatever `bit_i` carries.
- R4: On a clock edge where `clr_i` is 1, the register and the bit count go to zero. This holds even when `bit_en_i` is 1 in the same cycle.
- R5: Starting from zero, feed the 56 data bits of a code (bits 7:0 are the family field, then bits 55:8 are the serial field), each least significant bit first. `crc_o` then equals the CRC of those bits.
- R6: Appending the 8 bits of that CRC value (least significant bit first) after the 56 data bits leaves `crc_o` at 8'h00.
- R7: `code_ok_o` is 1 exactly when 64 bits have been shifted in since the last clear or reset and `crc_o` is 8'h00. After 63 bits it is 0.
- R8: `zero_o` is 1 exactly when `crc_o` is 8'h00.
- R9: The bit count saturates once it passes 64. After a 65th or later bit, `code_ok_o` stays 0 until the next clear, even if the residue is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the register and bit count |
| bit_en_i | input | 1 | Accept `bit_i` on this edge |
| bit_i | input | 1 | Serial data bit, least significant bit first |
| crc_o | output | 8 | Current register contents |
| zero_o | output | 1 | Register is all zeros |
| code_ok_o | output | 1 | Exactly 64 bits taken and residue zero |

## Verification
Single bits from a zero register separate the feedback taps and the shift direction, because a lone 1 must produce 8'h8C. Random 56-bit codes with fixed-seed `$urandom` are compared to a bench CRC function. The same codes with their CRC appended confirm the zero residue, and a copy with one bit flipped must not pass. An all-zero code tells the count condition apart from the residue condition: the residue is zero at 63, 64 and 65 bits, but only 64 may be flagged. A clear issued together with a bit, and idle cycles with `bit_i` toggling, show clear priority and hold.

// File: rtl/idcode_crc_pkg.sv
package idcode_crc_pkg;
  localparam int unsigned CRC_W     = 8;
  localparam int unsigned CODE_BITS = 64;
  typedef logic [CRC_W-1:0] crc_t;
  // reflected form of x^8+x^5+x^4+1
  localparam crc_t POLY_REFL = 8'h8C;
endpackage

// File: rtl/crc_serial_core.sv
module crc_serial_core #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] POLY = 8'h8C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         d_i,
  output logic [W-1:0] crc_o
);
  logic [W-1:0] crc_q, crc_d;
  logic fb;

  assign fb = d_i ^ crc_q[0];

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W-1) begin : g_top
      assign crc_d[i] = fb & POLY[i];
    end else begin : g_mid
      assign crc_d[i] = crc_q[i+1] ^ (fb & POLY[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (en_i)    crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (crc_q == '0));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(crc_q));
  assert_shift_nofb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && (d_i == crc_q[0])) |=> (crc_q == ($past(crc_q) >> 1)));
  assert_shift_fb_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && (d_i != crc_q[0])) |=> crc_q[W-1]);
endmodule

// File: rtl/code_bit_counter.sv
module code_bit_counter #(
  parameter int unsigned CODE_BITS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic full_o
);
  localparam int unsigned LIMIT = CODE_BITS + 1;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cnt_q <= '0;
    else if (clr_i)                           cnt_q <= '0;
    else if (en_i && cnt_q != CW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
  end

  assign full_o = (cnt_q == CW'(CODE_BITS));

  assert_sat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
  assert_clear_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  assert_cnt_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/idcode_crc8.sv
module idcode_crc8
  import idcode_crc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       bit_en_i,
  input  logic       bit_i,
  output logic [7:0] crc_o,
  output logic       zero_o,
  output logic       code_ok_o
);
  crc_t crc;
  logic full;

  crc_serial_core #(.W(CRC_W), .POLY(POLY_REFL)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .en_i  (bit_en_i),
    .d_i   (bit_i),
    .crc_o (crc)
  );

  code_bit_counter #(.CODE_BITS(CODE_BITS)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .en_i  (bit_en_i),
    .full_o(full)
  );

  assign crc_o     = crc;
  assign zero_o    = (crc == '0);
  assign code_ok_o = full & zero_o;

  assert_ok_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_ok_o |-> (crc_o == 8'h00));
  assert_clear_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!code_ok_o && zero_o));
  assert_zero_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> ($countones(crc_o) == 0));
endmodule

// File: tb/idcode_crc8_test.sv
module idcode_crc8_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, bit_en = 1'b0, bit_in = 1'b0;
  logic [7:0] crc;
  logic zero, code_ok;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  idcode_crc8 uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .bit_en_i(bit_en),
    .bit_i(bit_in), .crc_o(crc), .zero_o(zero), .code_ok_o(code_ok)
  );

  function automatic logic [7:0] ref_crc(input logic [63:0] v, input int n);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < n; i++) begin
      logic f;
      f = v[i] ^ c[0];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic b);
    bit_en = 1'b1; bit_in = b;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic send_n(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      send(v[i]);
      chk("R8", zero, crc == 8'h00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] code;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 crc", crc, 8'h00);
    chk("R1 zero", zero, 1'b1);
    chk("R1 ok", code_ok, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: single bits from zero
    send(1'b1);
    chk("R2 one", crc, 8'h8C);
    send(1'b0);
    chk("R2 shift", crc, 8'h46);
    send(1'b0);
    chk("R2 shift2", crc, 8'h23);
    send(1'b0);
    chk("R2 fb", crc, 8'h9D);

    // R3: idle with toggling data
    for (int i = 0; i < 6; i++) begin
      bit_in = i[0];
      @(negedge clk);
    end
    chk("R3 hold", crc, 8'h9D);

    // R4: clear with a bit offered in the same cycle
    clr = 1'b1; bit_en = 1'b1; bit_in = 1'b1;
    @(negedge clk);
    clr = 1'b0; bit_en = 1'b0;
    chk("R4 clr", crc, 8'h00);
    chk("R4 zero", zero, 1'b1);

    // R7/R9: all-zero code distinguishes count from residue
    send_n(64'h0, 63);
    chk("R7 63 bits", code_ok, 1'b0);
    send(1'b0);
    chk("R7 64 bits", code_ok, 1'b1);
    send(1'b0);
    chk("R9 65 bits", code_ok, 1'b0);
    send_n(64'h0, 10);
    chk("R9 saturated", code_ok, 1'b0);
    do_clear();
    chk("R4 count cleared", code_ok, 1'b0);

    // R5/R6/R7: random codes
    for (int k = 0; k < 30; k++) begin
      code[31:0]  = $urandom;
      code[55:32] = 24'($urandom);
      code[63:56] = ref_crc(code, 56);
      do_clear();
      send_n(code, 56);
      chk("R5 crc", crc, code[63:56]);
      chk("R7 at 56", code_ok, 1'b0);
      for (int j = 0; j < 3; j++) begin
        bit_in = ~bit_in;
        @(negedge clk);
      end
      chk("R3 mid-code hold", crc, code[63:56]);
      send_n(code >> 56, 8);
      chk("R6 residue", crc, 8'h00);
      chk("R7 ok", code_ok, 1'b1);
      if (k % 5 == 0) begin
        int p;
        p = int'($urandom % 64);
        code[p] = ~code[p];
        do_clear();
        send_n(code, 64);
        chk("R7 corrupt", code_ok, 1'b0);
        chk("R2 corrupt residue", crc, ref_crc(code, 64));
      end
    end

    // random partial lengths against the model
    for (int k = 0; k < 20; k++) begin
      int n;
      code = {$urandom, $urandom};
      n = 1 + int'($urandom % 64);
      do_clear();
      send_n(code, n);
      chk("R2 partial", crc, ref_crc(code, n));
      chk("R7 partial", code_ok, (n == 64) && (ref_crc(code, n) == 8'h00));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule